// File: doc/BRIEF.md
# Periodic Comparator Event Timer

The block is a memory-mapped event timer. It has one free-running main counter and one comparator channel. Software programs it through a simple register port with single-cycle write and read strobes. The channel raises an interrupt when the main counter reaches the comparator value. In periodic mode the channel re-arms itself by adding a stored period to the comparator.

The channel keeps its period in a register of its own, beside the comparator. A self-clearing "set-value" control lets software program a periodic timer while the counter is running and not at zero. Software first reads the counter, then makes two comparator writes in a row. The first write sets the absolute first expiry. The second write sets only the period. A legacy-route enable moves the channel interrupt from its normal output to a separate legacy interrupt output.

Reads return data one cycle after the read strobe. Register offsets, as byte addresses on `addr`:

| Offset | Register |
|--------|----------|
| 0x000 | capability |
| 0x010 | global configuration |
| 0x020 | status |
| 0x0F0 | main counter |
| 0x100 | channel configuration |
| 0x108 | channel comparator |

Top module: `cmp_event_timer`

## Requirements
- R1: Global configuration bit 0 (run) enables the main counter (offset 0xF0). While run is set, the counter rises by one every clock. While run is clear, the counter holds its value. A write to the counter loads the written value, and this write takes priority over counting.
- R2: The capability word (offset 0x000) is read-only. Bit 0 reads 1 when legacy routing is supported. Bit 1 reads 1 when the counter is wider than 32 bits. With the default parameters it reads 0x3, and writes to it have no effect.
- R3: Channel configuration (offset 0x100) has four bits: bit 0 interrupt enable, bit 1 periodic, bit 2 set-value, bit 3 force-32. When set-value is clear and no set-value sequence is pending, a write to the comparator (offset 0x108) loads both the comparator and the period with the written value.
- R4: While set-value is set, a comparator write loads only the comparator and clears set-value. The next comparator write then loads only the period and leaves the comparator unchanged. A write to channel configuration cancels a pending period-only write.
- R5: A match happens when run is set, interrupt enable is set, and the counter equals the comparator. A match sets status bit 0 on the next edge. Writing 1 to status bit 0 (offset 0x20) clears it. A match in the same cycle as the clear wins.
- R6: In periodic mode, each match adds the period to the comparator on the same edge that sets the status bit.
- R7: In one-shot mode (periodic clear), a match leaves the comparator unchanged.
- R8: With force-32 set, three things use only the low 32 bits: the match compare, the periodic addition (which wraps modulo 2^32, with the upper bits zero), and values written to the comparator and period.
- R9: The interrupt is status bit 0 AND interrupt enable. If global configuration bit 1 (legacy route) is set, the interrupt drives `irq_legacy`. Otherwise it drives `irq_chan`. The two outputs are never high together.
- R10: `rdata` updates on the edge where `rd_en` is high and holds otherwise. It resets to 0. The counter read returns the value before that edge's increment. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| wr_en | input | 1 | single-cycle write strobe |
| rd_en | input | 1 | single-cycle read strobe |
| addr | input | 12 | register byte offset |
| wdata | input | CNT_W | write data |
| rdata | output | CNT_W | read data, valid the cycle after rd_en |
| irq_chan | output | 1 | channel interrupt, normal route |
| irq_legacy | output | 1 | channel interrupt, legacy route |

## Verification
The bench builds the timer with its defaults: a 64-bit counter and legacy routing present. This lets one build cover both the full-width compare and force-32 mode. In force-32 mode the bench loads the counter just below a 2^32 boundary with nonzero upper bits. It then programs a periodic channel whose next expiry wraps past that boundary. The set-value sequence is run while the counter is moving and on both interrupt routes, and a behavioural model predicts every cycle.

// File: rtl/tmr_pkg.sv
// Shared offsets, bit positions and the channel configuration type of the event timer.
// Assumes byte offsets on a 12-bit address and a counter width of 32 to 64 bits.
package tmr_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CAP  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_GCFG = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STS  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CCFG = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 12'h108;

    localparam int GBIT_RUN = 0;
    localparam int GBIT_LEG = 1;

    // Packed so that bit 0 = irq enable, 1 = periodic, 2 = set-value, 3 = force-32.
    typedef struct packed {
        logic w32;
        logic setv;
        logic per;
        logic ie;
    } chan_cfg_t;
endpackage

// File: rtl/tmr_main_counter.sv
// Main counter of the event timer. It counts up by one per clock while run is high.
// A load takes priority over counting. Reset is synchronous, active low, and clears the count.
module tmr_main_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt
);
    // Count register: reset, load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (run)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/tmr_channel.sv
// One comparator channel: configuration, comparator, period, set-value sequencing,
// match detection and the sticky status bit.
// Assumes 32 <= CNT_W <= 64. The caller decodes the strobes (cfg_we, cmp_we, sts_clr).
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_we,
    input  chan_cfg_t        cfg_wd,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wd,
    input  logic             sts_clr,
    output chan_cfg_t        cfg,
    output logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] per,
    output logic             per_next,
    output logic             sts,
    output logic             hit
);
    localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'(64'hFFFF_FFFF);

    // Keep only the low 32 bits when narrow is set.
    function automatic logic [CNT_W-1:0] trim(input logic [CNT_W-1:0] v, input logic narrow);
        return narrow ? (v & LOW_MASK) : v;
    endfunction

    logic             load_cmp;
    logic             load_per;
    logic [CNT_W-1:0] wd_trim;
    logic [CNT_W-1:0] reload;

    // Match detection, write steering and the next periodic expiry.
    always_comb begin
        hit      = run && cfg.ie && (trim(cnt, cfg.w32) == trim(cmp, cfg.w32));
        load_cmp = cmp_we && (cfg.setv || !per_next);
        load_per = cmp_we && !cfg.setv;
        wd_trim  = trim(cmp_wd, cfg.w32);
        reload   = trim(cmp + per, cfg.w32);
    end

    // Configuration register; set-value clears itself on the comparator write that uses it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (cfg_we)
            cfg <= cfg_wd;
        else if (cmp_we && cfg.setv)
            cfg.setv <= 1'b0;
    end

    // Pending period-only write that follows a set-value comparator write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_next <= 1'b0;
        else if (cfg_we)
            per_next <= 1'b0;
        else if (cmp_we)
            per_next <= cfg.setv;
    end

    // Comparator: a software write wins over the periodic re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp <= '0;
        else if (load_cmp)
            cmp <= wd_trim;
        else if (hit && cfg.per)
            cmp <= reload;
    end

    // Period register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per <= '0;
        else if (load_per)
            per <= wd_trim;
    end

    // Sticky status bit: a new match wins over the write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sts <= 1'b0;
        else
            sts <= (sts && !sts_clr) || hit;
    end
endmodule

// File: rtl/cmp_event_timer.sv
// Top of the event timer: register decode, global configuration, registered read
// mux and interrupt routing.
// Assumes single-cycle strobes and that read data is used one cycle after rd_en.
module cmp_event_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter bit LEG_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq_chan,
    output logic              irq_legacy
);
    localparam logic [CNT_W-1:0] CAP_WORD =
        CNT_W'({(CNT_W > 32) ? 1'b1 : 1'b0, LEG_CAP});

    logic             run;
    logic             leg;
    logic [CNT_W-1:0] cnt;
    chan_cfg_t        cfg;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] per;
    logic             per_next;
    logic             sts;
    logic             hit;
    logic             we_gcfg, we_cnt, we_ccfg, we_cmp, sts_clr;

    // Write decode.
    always_comb begin
        we_gcfg = wr_en && (addr == OFS_GCFG);
        we_cnt  = wr_en && (addr == OFS_CNT);
        we_ccfg = wr_en && (addr == OFS_CCFG);
        we_cmp  = wr_en && (addr == OFS_CMP);
        sts_clr = wr_en && (addr == OFS_STS) && wdata[0];
    end

    // Run bit of the global configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (we_gcfg)
            run <= wdata[GBIT_RUN];
    end

    // The legacy route bit is stored only when the capability is present.
    generate
        if (LEG_CAP) begin : g_leg
            // Legacy route bit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    leg <= 1'b0;
                else if (we_gcfg)
                    leg <= wdata[GBIT_LEG];
            end
        end else begin : g_noleg
            assign leg = 1'b0;
        end
    endgenerate

    tmr_main_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .ld     (we_cnt),
        .ld_val (wdata),
        .cnt    (cnt)
    );

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cnt      (cnt),
        .cfg_we   (we_ccfg),
        .cfg_wd   (chan_cfg_t'(wdata[3:0])),
        .cmp_we   (we_cmp),
        .cmp_wd   (wdata),
        .sts_clr  (sts_clr),
        .cfg      (cfg),
        .cmp      (cmp),
        .per      (per),
        .per_next (per_next),
        .sts      (sts),
        .hit      (hit)
    );

    // Registered read mux; unmapped offsets read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en) begin
            case (addr)
                OFS_CAP:  rdata <= CAP_WORD;
                OFS_GCFG: rdata <= CNT_W'({leg, run});
                OFS_STS:  rdata <= CNT_W'(sts);
                OFS_CNT:  rdata <= cnt;
                OFS_CCFG: rdata <= CNT_W'(cfg);
                OFS_CMP:  rdata <= cmp;
                default:  rdata <= '0;
            endcase
        end
    end

    // Interrupt routing between the normal and legacy outputs.
    always_comb begin
        irq_chan   = sts && cfg.ie && !leg;
        irq_legacy = sts && cfg.ie && leg;
    end
endmodule

// File: rtl/tmr_checker.sv
// Property checker for cmp_event_timer, attached with bind. It only observes signals.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic [CNT_W-1:0]  per,
    input logic              per_next,
    input logic              ch_per,
    input logic              ch_w32,
    input logic              ch_setv,
    input logic              sts,
    input logic              hit,
    input logic              irq_chan,
    input logic              irq_legacy
);
    logic cnt_wr, cmp_wr;
    assign cnt_wr = wr_en && (addr == OFS_CNT);
    assign cmp_wr = wr_en && (addr == OFS_CMP);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1))); // R1
    AST_SETV_PER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && per_next && !ch_setv && !hit) |=> $stable(cmp)); // R4
    AST_SETV_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && ch_setv && !(wr_en && addr == OFS_CCFG)) |=> !ch_setv); // R4
    AST_STS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> sts); // R5
    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ch_per && !ch_w32 && !cmp_wr) |=> (cmp == $past(cmp) + $past(per))); // R6
    AST_ONESHOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !ch_per && !cmp_wr) |=> $stable(cmp)); // R7
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_chan && irq_legacy)); // R9
endmodule

bind cmp_event_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .run        (run),
    .cnt        (cnt),
    .cmp        (cmp),
    .per        (per),
    .per_next   (per_next),
    .ch_per     (cfg.per),
    .ch_w32     (cfg.w32),
    .ch_setv    (cfg.setv),
    .sts        (sts),
    .hit        (hit),
    .irq_chan   (irq_chan),
    .irq_legacy (irq_legacy)
);

// File: tb/cmp_event_timer_bench.sv
// Bench for cmp_event_timer. A behavioural model is stepped on every clock and compared
// with the outputs 1 ns after each rising edge. Inputs are driven on falling edges.
module cmp_event_timer_bench;
    localparam int CNT_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [11:0]      addr = '0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             irq_chan, irq_legacy;

    int    n_chk = 0;
    int    n_err = 0;
    int    cycles = 0;
    string cur_req = "R10";

    always #2 clk = ~clk;

    cmp_event_timer #(.CNT_W(CNT_W), .LEG_CAP(1'b1)) u_cmp_event_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_chan(irq_chan), .irq_legacy(irq_legacy)
    );

    // Reference model state.
    longint unsigned m_cnt, m_cmp, m_per, m_rd;
    bit m_run, m_leg, m_ie, m_pm, m_sv, m_w32, m_pn, m_sts;

    function automatic longint unsigned tr(longint unsigned v, bit narrow);
        return narrow ? (v & 64'hFFFF_FFFF) : v;
    endfunction

    task automatic check(string what, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h at t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Model step on each edge, then comparison once the design has settled.
    always @(posedge clk) begin
        bit hit;
        longint unsigned wd;
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_per = 0; m_rd = 0;
            m_run = 0; m_leg = 0; m_ie = 0; m_pm = 0; m_sv = 0; m_w32 = 0; m_pn = 0; m_sts = 0;
        end else begin
            hit = m_run && m_ie && (tr(m_cnt, m_w32) == tr(m_cmp, m_w32));
            wd  = wdata;
            if (rd_en) begin
                case (addr)
                    12'h000: m_rd = 3;
                    12'h010: m_rd = {m_leg, m_run};
                    12'h020: m_rd = m_sts;
                    12'h0F0: m_rd = m_cnt;
                    12'h100: m_rd = {m_w32, m_sv, m_pm, m_ie};
                    12'h108: m_rd = m_cmp;
                    default: m_rd = 0;
                endcase
            end
            m_sts = (m_sts && !(wr_en && addr == 12'h020 && wd[0])) || hit;
            if (hit && m_pm) m_cmp = tr(m_cmp + m_per, m_w32);
            if (wr_en && addr == 12'h0F0) m_cnt = wd;
            else if (m_run) m_cnt = m_cnt + 1;
            if (wr_en && addr == 12'h108) begin
                if (m_sv) begin
                    m_cmp = tr(wd, m_w32); m_sv = 0; m_pn = 1;
                end else if (m_pn) begin
                    m_per = tr(wd, m_w32); m_pn = 0;
                end else begin
                    m_cmp = tr(wd, m_w32); m_per = tr(wd, m_w32);
                end
            end
            if (wr_en && addr == 12'h100) begin
                m_ie = wd[0]; m_pm = wd[1]; m_sv = wd[2]; m_w32 = wd[3]; m_pn = 0;
            end
            if (wr_en && addr == 12'h010) begin
                m_run = wd[0]; m_leg = wd[1];
            end
        end
        #1;
        check("rdata", rdata, m_rd);
        check("irq_chan", irq_chan, m_sts && m_ie && !m_leg);
        check("irq_legacy", irq_legacy, m_sts && m_ie && m_leg);
    end

    // Tasks start on a falling edge and end on the next one.
    task automatic wr(input logic [11:0] a, input longint unsigned d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        wait (cycles > 50000);
        n_chk++; n_err++;
        $display("FAIL watchdog act=%0d exp=<50000 cycles", cycles);
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R10: reset state and unmapped reads.
        cur_req = "R10";
        rd(12'h010); rd(12'h020); rd(12'h0F0); rd(12'h100); rd(12'h108);
        rd(12'h018); rd(12'h200); rd(12'hFFF);
        // R2: capability is fixed and ignores writes.
        cur_req = "R2";
        rd(12'h000); wr(12'h000, 64'hFF); rd(12'h000);
        // R1: counting, holding, loading.
        cur_req = "R1";
        wr(12'h010, 1); idle(5); rd(12'h0F0); rd(12'h0F0);
        wr(12'h010, 0); idle(3); rd(12'h0F0); idle(2); rd(12'h0F0);
        wr(12'h0F0, 100); rd(12'h0F0);
        // R3, R7: plain comparator write, one-shot match; R5: status clear.
        cur_req = "R3";
        wr(12'h100, 64'h1); wr(12'h108, 130); rd(12'h108);
        cur_req = "R7";
        wr(12'h010, 1); idle(40); rd(12'h108); rd(12'h020);
        cur_req = "R5";
        wr(12'h020, 1); rd(12'h020); idle(2);
        // R5: no match with interrupt enable clear.
        wr(12'h100, 64'h0); wr(12'h108, m_cnt + 6); idle(12); rd(12'h020);
        // R5: no match while the counter is stopped at the comparator value.
        wr(12'h010, 0); wr(12'h100, 64'h1); wr(12'h108, m_cnt); idle(4); rd(12'h020);
        // R4, R6, R9: set-value period programming on the legacy route.
        cur_req = "R4";
        wr(12'h010, 3);
        wr(12'h100, 64'h7); rd(12'h100);
        wr(12'h108, m_cnt + 30);
        wr(12'h108, 25);
        rd(12'h100); rd(12'h108);
        cur_req = "R6";
        for (int i = 0; i < 12; i++) begin
            idle(9); wr(12'h020, 1); rd(12'h108);
        end
        // R9: normal route with the same channel.
        cur_req = "R9";
        wr(12'h010, 1);
        for (int i = 0; i < 4; i++) begin
            idle(10); wr(12'h020, 1);
        end
        // R4: a configuration write cancels the pending period-only write.
        cur_req = "R4";
        wr(12'h100, 64'h7); wr(12'h108, m_cnt + 50); wr(12'h100, 64'h3);
        wr(12'h108, m_cnt + 40); rd(12'h108); idle(50); rd(12'h108);
        // R8: force-32 match and wraparound across 2^32 with nonzero upper bits.
        cur_req = "R8";
        wr(12'h010, 0); wr(12'h020, 1);
        wr(12'h0F0, 64'h1_FFFF_FFE0);
        wr(12'h100, 64'hF);
        wr(12'h108, 64'hAB_FFFF_FFF8);
        wr(12'h108, 16);
        rd(12'h108);
        wr(12'h010, 1);
        for (int i = 0; i < 6; i++) begin
            idle(7); wr(12'h020, 1); rd(12'h108);
        end
        wr(12'h108, 64'h77_0000_0005); rd(12'h108);
        wr(12'h010, 0);
        idle(4);
        finish_run();
    end
endmodule